// File: doc/BRIEF.md
# Software Watchdog Timer with Sticky Expiry Cause

This block is a down-counting supervision timer that runs on the system clock. Software first writes a reload value and then writes the control register. That write picks what happens on expiry and sets the enable bit. Software must then write the kick register over and over so the count never reaches zero. If the count does reach zero, the block takes the selected action:

- it pulses a system reset request for a fixed number of clocks, or
- it raises a non-maskable interrupt line, or
- it raises an ordinary interrupt line, or
- it takes no outward action.

On every expiry a sticky cause flag is set. The watchdog's own reset request clears the enable bit and the action field, but it leaves the cause flag untouched. After the system comes back up, software reads the flag to learn whether the watchdog caused the restart. Only the power-on reset input or a write-one-to-clear removes the flag.

The register port is a simple single-cycle write strobe with a combinational read mux. The power-on reset is asynchronous and active low. It is released on the clock through a two-stage synchronizer.

Top module: `wdog_timer`

## Requirements
- R1: After power-on reset the block is in this state: control reads 0 (enable off, action none, cause flag clear), the reload register reads all ones, the count reads 0, and rst_req, nmi and irq are low.
- R2: Register map, selected by addr:
  - addr 0 is control: bit 0 enable, bits 2:1 action (0 none, 1 reset, 2 non-maskable interrupt, 3 interrupt), bit 8 cause flag.
  - addr 1 is the reload value.
  - addr 2 reads the live count.
  - A control write that turns enable from 0 to 1 copies the reload value into the count at that clock edge.
- R3: While enabled with a nonzero count and no write, the count falls by exactly one per clock.
- R4: Any write to addr 2 (a kick) copies the reload value into the count and withdraws a held nmi or irq at the same edge.
- R5: With action reset, one clock after the count reads zero, rst_req goes high for exactly 4 clocks (parameter RST_CYCLES). At that same edge, enable and action are cleared to 0.
- R6: The cause flag is set on every expiry. It survives the reset-action expiry. Writing 1 to control bit 8 clears it, and power-on reset clears it. An expiry in the same cycle as the clear leaves it set.
- R7: With action 2, nmi rises one clock after the count reads zero and stays high. The count stays at zero until a kick or a disable.
- R8: With action 3, irq behaves the same way as nmi does under R7.
- R9: With action 0, expiry only sets the cause flag: rst_req, nmi and irq stay low, and the count stays at zero.
- R10: A control write with enable 0 freezes the count from the next clock on and drops nmi or irq at once.
- R11: A control write with enable 1 while already enabled does not reload the count.
- R12: Writing the reload register does not change a running count; the new value is used on the next kick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 2 | Register select for writes and reads |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data for addr, combinational |
| rst_req | output | 1 | System reset request pulse |
| nmi | output | 1 | Non-maskable interrupt request, level |
| irq | output | 1 | General interrupt request, level |

## Verification
The bench checks the exact cycle of expiry: the event must appear one clock after the count reads zero. A design that fires at count one, or that wraps past zero, would miss that cycle.

It checks that the reset pulse is exactly RST_CYCLES long. It also checks that the pulse leaves the cause flag set while clearing enable and action. A design that clears all state on its own reset would lose the cause flag.

It checks that re-writing enable while running, or changing the reload value, leaves the live count alone. A design that reloads on every control write would never expire under software that rewrites the control register.

It checks that disable and kick withdraw a held interrupt at once, and that the "none" action stays silent.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_RESET = 2'd1,
    ACT_NMI   = 2'd2,
    ACT_IRQ   = 2'd3
  } wd_act_e;

  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] REG_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] REG_LOAD  = 2'd1;
  localparam logic [ADDR_W-1:0] REG_COUNT = 2'd2;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_ACT_LSB  = 1;
  localparam int CTRL_STAT_BIT = 8;
endpackage

// File: rtl/wdog_ctrl_regs.sv
module wdog_ctrl_regs
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] LOAD_INIT = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic              expire_evt,
  output logic              en,
  output wd_act_e           act,
  output logic              status,
  output logic [CNT_W-1:0]  load_val,
  output logic              load_now
);
  logic              en_q, en_d;
  wd_act_e           act_q, act_d;
  logic              status_q, status_d;
  logic [CNT_W-1:0]  load_q;
  logic              ctrl_wr, load_wr, kick, en_rise, self_reset;
  logic              ctrl_ce, load_ce, status_ce;

  always_comb begin
    ctrl_wr    = wr_en && (addr == REG_CTRL);
    load_wr    = wr_en && (addr == REG_LOAD);
    kick       = wr_en && (addr == REG_COUNT);
    en_rise    = ctrl_wr && wdata[CTRL_EN_BIT] && !en_q;
    self_reset = expire_evt && (act_q == ACT_RESET);

    en_d  = en_q;
    act_d = act_q;
    if (ctrl_wr) begin
      en_d  = wdata[CTRL_EN_BIT];
      act_d = wd_act_e'(wdata[CTRL_ACT_LSB +: 2]);
    end
    if (self_reset) begin
      en_d  = 1'b0;
      act_d = ACT_NONE;
    end

    status_d = status_q;
    if (ctrl_wr && wdata[CTRL_STAT_BIT]) status_d = 1'b0;
    if (expire_evt)                      status_d = 1'b1;

    ctrl_ce   = ctrl_wr || self_reset;
    load_ce   = load_wr;
    status_ce = expire_evt || ctrl_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      act_q <= ACT_NONE;
    end else if (ctrl_ce) begin
      en_q  <= en_d;
      act_q <= act_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status_q <= 1'b0;
    else if (status_ce) status_q <= status_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       load_q <= LOAD_INIT;
    else if (load_ce) load_q <= wdata;
  end

  assign en       = en_q;
  assign act      = act_q;
  assign status   = status_q;
  assign load_val = load_q;
  assign load_now = kick || en_rise;
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             load_now,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             expire_evt,
  output logic             expired
);
  logic [CNT_W-1:0] count_q, count_d;
  logic             expired_q, expired_d;
  logic             cnt_zero, cnt_ce, exp_ce;

  always_comb begin
    cnt_zero   = (count_q == '0);
    expire_evt = en && cnt_zero && !expired_q && !load_now;

    cnt_ce  = load_now || (en && !cnt_zero);
    count_d = load_now ? load_val : (count_q - 1'b1);

    exp_ce    = !en || load_now || expire_evt;
    expired_d = (!en || load_now) ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= '0;
    else if (cnt_ce) count_q <= count_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      expired_q <= 1'b0;
    else if (exp_ce) expired_q <= expired_d;
  end

  assign count   = count_q;
  assign expired = expired_q;
endmodule

// File: rtl/wdog_event_gen.sv
module wdog_event_gen
  import wdog_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    en,
  input  wd_act_e act,
  input  logic    expire_evt,
  input  logic    expired,
  output logic    rst_req,
  output logic    nmi,
  output logic    irq
);
  localparam int PW = $clog2(RST_CYCLES + 1);

  logic [PW-1:0] pulse_q, pulse_d;
  logic          pulse_ce, start;

  always_comb begin
    start    = expire_evt && (act == ACT_RESET);
    pulse_ce = start || (pulse_q != '0);
    pulse_d  = start ? PW'(RST_CYCLES) : (pulse_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pulse_q <= '0;
    else if (pulse_ce) pulse_q <= pulse_d;
  end

  assign rst_req = (pulse_q != '0);
  assign nmi     = en && expired && (act == ACT_NMI);
  assign irq     = en && expired && (act == ACT_IRQ);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int RST_CYCLES = 4,
  parameter logic [CNT_W-1:0] LOAD_INIT = '1
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              rst_req,
  output logic              nmi,
  output logic              irq
);
  logic [1:0]       rst_sync_q;
  logic             rst_sync_n;
  logic             en_q, status_q, load_now, expire_evt, expired;
  wd_act_e          act_q;
  logic [CNT_W-1:0] load_q, count_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  wdog_ctrl_regs #(.CNT_W(CNT_W), .LOAD_INIT(LOAD_INIT)) i_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .expire_evt(expire_evt), .en(en_q), .act(act_q), .status(status_q),
    .load_val(load_q), .load_now(load_now)
  );

  wdog_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk(clk), .rst_n(rst_sync_n), .en(en_q), .load_now(load_now),
    .load_val(load_q), .count(count_q), .expire_evt(expire_evt), .expired(expired)
  );

  wdog_event_gen #(.RST_CYCLES(RST_CYCLES)) i_evt (
    .clk(clk), .rst_n(rst_sync_n), .en(en_q), .act(act_q),
    .expire_evt(expire_evt), .expired(expired),
    .rst_req(rst_req), .nmi(nmi), .irq(irq)
  );

  always_comb begin
    rdata = '0;
    case (addr)
      REG_CTRL: begin
        rdata[CTRL_EN_BIT]           = en_q;
        rdata[CTRL_ACT_LSB +: 2]     = act_q;
        rdata[CTRL_STAT_BIT]         = status_q;
      end
      REG_LOAD:  rdata = load_q;
      REG_COUNT: rdata = count_q;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int CNT_W = 32,
  parameter int RST_CYCLES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic [CNT_W-1:0] wdata,
  input logic [CNT_W-1:0] count,
  input logic             en,
  input logic             status,
  input logic             rst_req,
  input logic             nmi,
  input logic             irq
);
  logic [31:0] rst_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rst_len <= '0;
    else if (rst_req) rst_len <= rst_len + 1;
    else              rst_len <= '0;
  end

  assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (count != '0) && !wr_en) |=> (count == $past(count) - 1'b1));

  assert_hold_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (count == '0) && !wr_en) |=> (count == '0));

  assert_status_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !(wr_en && (addr == 2'd0) && wdata[8])) |=> status);

  assert_rst_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (rst_len < RST_CYCLES));

  assert_rst_disables_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> (!en && status));

  assert_int_needs_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi || irq) |-> en);

  assert_int_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nmi, irq}));
endmodule

bind wdog_timer wdog_checker #(.CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)) i_wdog_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .count(count_q), .en(en_q), .status(status_q),
  .rst_req(rst_req), .nmi(nmi), .irq(irq)
);

// File: tb/test_wdog_timer.sv
module test_wdog_timer;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         por_n;
  logic         wr_en;
  logic [1:0]   addr;
  logic [W-1:0] wdata;
  logic [W-1:0] rdata;
  logic         rst_req, nmi, irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdog_timer i_wdog_timer (
    .clk(clk), .por_n(por_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rst_req(rst_req), .nmi(nmi), .irq(irq)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic chk_outs(input string req, input logic r, input logic n, input logic i);
    chk(req, {29'd0, rst_req, nmi, irq}, {29'd0, r, n, i});
  endtask

  task automatic t_reset_state();
    logic [W-1:0] d;
    rd(0, d); chk("R1 ctrl", d, 0);
    rd(1, d); chk("R1 load", d, 32'hFFFF_FFFF);
    rd(2, d); chk("R1 count", d, 0);
    chk_outs("R1 outputs", 0, 0, 0);
  endtask

  task automatic t_irq_action();
    logic [W-1:0] d;
    wr(1, 5);
    wr(0, 32'h7);                       // enable, action 3
    rd(2, d); chk("R2 load on enable", d, 5);
    step(2); rd(2, d); chk("R3 decrement", d, 3);
    step(3); rd(2, d); chk("R3 reaches zero", d, 0);
    chk_outs("R8 no irq at zero yet", 0, 0, 0);
    step(1); chk_outs("R8 irq raised", 0, 0, 1);
    rd(0, d); chk("R6 flag set by irq expiry", d[8], 1);
    step(3); chk_outs("R8 irq held", 0, 0, 1);
    rd(2, d); chk("R8 count held at zero", d, 0);
    wr(2, 0);
    chk_outs("R4 kick drops irq", 0, 0, 0);
    rd(2, d); chk("R4 kick reloads", d, 5);
    wr(0, 32'h6);
  endtask

  task automatic t_w1c();
    logic [W-1:0] d;
    wr(0, 32'h100);
    rd(0, d); chk("R6 write-one clears flag", d[8], 0);
  endtask

  task automatic t_nmi_action();
    logic [W-1:0] d;
    wr(1, 4);
    wr(0, 32'h5);                       // enable, action 2
    step(4); chk_outs("R7 quiet before expiry", 0, 0, 0);
    step(1); chk_outs("R7 nmi raised", 0, 1, 0);
    step(2); chk_outs("R7 nmi held", 0, 1, 0);
    rd(2, d); chk("R7 count held at zero", d, 0);
    wr(2, 0);
    chk_outs("R4 kick drops nmi", 0, 0, 0);
    rd(2, d); chk("R4 kick reloads nmi", d, 4);
    wr(0, 32'h4);
  endtask

  task automatic t_none_action();
    logic [W-1:0] d;
    wr(1, 2);
    wr(0, 32'h101);                     // clear flag, enable, action 0
    step(2); rd(0, d); chk("R9 flag clear before expiry", d[8], 0);
    step(1); rd(0, d); chk("R9 flag set", d[8], 1);
    chk_outs("R9 no outputs", 0, 0, 0);
    step(3); chk_outs("R9 still silent", 0, 0, 0);
    rd(2, d); chk("R9 count stays zero", d, 0);
    wr(0, 32'h100);
  endtask

  task automatic t_rewrite_and_load();
    logic [W-1:0] d;
    wr(1, 100);
    wr(0, 32'h7);
    step(10); rd(2, d); chk("R3 ten decrements", d, 90);
    wr(0, 32'h7);
    rd(2, d); chk("R11 no reload on re-enable", d, 89);
    wr(1, 50);
    rd(2, d); chk("R12 load write keeps count", d, 88);
    rd(1, d); chk("R12 load register updated", d, 50);
    wr(2, 0);
    rd(2, d); chk("R4 kick uses new load", d, 50);
    wr(0, 32'h6);
  endtask

  task automatic t_disable();
    logic [W-1:0] d;
    wr(1, 20);
    wr(0, 32'h7);
    step(5); rd(2, d); chk("R3 running", d, 15);
    wr(0, 32'h6);
    rd(2, d); chk("R10 last decrement", d, 14);
    step(3); rd(2, d); chk("R10 count frozen", d, 14);
    wr(1, 1);
    wr(0, 32'h7);
    step(2); chk_outs("R8 irq for disable test", 0, 0, 1);
    wr(0, 32'h6);
    chk_outs("R10 disable drops irq", 0, 0, 0);
  endtask

  task automatic t_reset_action();
    logic [W-1:0] d;
    wr(1, 3);
    wr(0, 32'h103);                     // clear flag, enable, action 1
    step(3); chk_outs("R5 no pulse at zero yet", 0, 0, 0);
    step(1); chk_outs("R5 pulse begins", 1, 0, 0);
    rd(0, d); chk("R5 R6 enable and action cleared, flag kept", d, 32'h100);
    for (int k = 2; k <= 4; k++) begin
      step(1); chk_outs("R5 pulse continues", 1, 0, 0);
    end
    step(1); chk_outs("R5 pulse ends after 4", 0, 0, 0);
    rd(0, d); chk("R6 flag survives self reset", d[8], 1);
  endtask

  task automatic t_por();
    logic [W-1:0] d;
    por_n = 1'b0;
    step(2);
    por_n = 1'b1;
    step(4);
    rd(0, d); chk("R1 R6 power-on clears flag", d, 0);
  endtask

  initial begin
    por_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    step(3);
    por_n = 1'b1;
    step(4);
    t_reset_state();
    t_irq_action();
    t_w1c();
    t_nmi_action();
    t_none_action();
    t_rewrite_and_load();
    t_disable();
    t_reset_action();
    t_por();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog timeout actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule